// File: doc/BRIEF.md
# Sub-CPU Interval Timer, Stopwatch and Level-2 Interrupt Latch

This block runs from the sub-CPU clock, one clock per sub-CPU cycle. It holds two timers that share one prescale length of `PRESCALE` cycles (384 by default). The interval timer is loaded with an 8-bit value N. While N is nonzero it raises a level-3 interrupt request every (N+1) prescale periods, and the request stays up until the CPU acknowledges it. The stopwatch counts whole prescale periods in a 12-bit field, and any write to it sets it back to zero.

The block also holds the level-2 interrupt that the main CPU sends to the sub-CPU. A main-CPU write with its data bit set latches a pending flag. The main CPU can read that flag back together with the level-2 enable bit of the mask register. The flag is cleared when the sub-CPU acknowledges the interrupt, or when a mask write switches the enable from on to off.

The interval timer is a two-state machine. `IVT_OFF` moves to `IVT_RUN` on a write of a nonzero N. `IVT_RUN` returns to `IVT_OFF` on a write of zero. A write of a nonzero N in `IVT_RUN` keeps the state and restarts the period. The level-2 latch is a second two-state machine. `L2_IDLE` moves to `L2_PEND` on a main-CPU set. `L2_PEND` returns to `L2_IDLE` on an acknowledge or on a mask-off write, unless a set arrives in the same cycle, in which case the set wins. Priority encoding of interrupt levels into the CPU lies outside this block.

Top module: `subcpu_timers`

## Requirements
- R1: After reset, irq3_req, irq2_req and main_status are 0, and the interval register (select 0), the stopwatch (select 1) and the mask (select 2) all read 0.
- R2: Let a write of nonzero N to select 0 be captured at clock edge W. irq3_req is low through edge W+(N+1)*PRESCALE-1 and goes high at edge W+(N+1)*PRESCALE. The timer then reloads, so the next expiry falls at W+2*(N+1)*PRESCALE.
- R3: A write of 0 to select 0 stops the interval timer, and no level-3 request is raised afterwards.
- R4: Reading select 0 returns the last value written to it, zero-extended.
- R5: Once raised, irq3_req stays high until irq3_ack is asserted for one cycle, and it is low after that edge.
- R6: Any write to select 0 restarts the prescaler, so the next expiry is timed from the new write and not from the earlier one.
- R7: Reading select 1 returns the number of whole PRESCALE-cycle periods since the stopwatch was last cleared, modulo 4096 (12 bits).
- R8: Any write to select 1 clears the stopwatch count and its prescaler, whatever the data.
- R9: A main_we pulse with main_bit=1 sets the level-2 pending flag, shown on main_status[0]. A pulse with main_bit=0 leaves the flag unchanged.
- R10: An irq2_ack pulse clears the level-2 pending flag.
- R11: A mask write (select 2) whose bit 2 is 0, while the stored bit 2 is 1, clears the pending flag. A mask write that leaves bit 2 at 1, or that writes 0 while it is already 0, leaves the flag unchanged.
- R12: irq2_req is high exactly when the pending flag and the mask enable (bit 2) are both set. main_status[1] shows the enable.
- R13: Reading select 2 returns the full mask byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-CPU clock, one cycle per sub-CPU cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 interval, 1 stopwatch, 2 mask |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| main_we | input | 1 | Main-CPU write strobe for the level-2 request bit |
| main_bit | input | 1 | Level-2 request data bit |
| main_status | output | 2 | Bit 1 level-2 enable, bit 0 level-2 pending |
| irq2_req | output | 1 | Level-2 interrupt request |
| irq2_ack | input | 1 | Level-2 acknowledge |
| irq3_req | output | 1 | Level-3 interrupt request |
| irq3_ack | input | 1 | Level-3 acknowledge |

## Verification
The interval timer is driven with a seeded random series of small N values. Each expiry is checked one cycle before and exactly at (N+1) prescale periods, which separates an N-period count from an N+1-period count. Directed cases cover a rewrite in mid-period, which tells a restarted prescaler from a free-running one, and a write of zero both before and after an expiry. The stopwatch is read at random period boundaries, on both sides of each step, and across the 4096 wrap. The level-2 latch is driven through set-while-disabled, set with data 0, acknowledge, re-enable while already on, and disable, which separates clearing on a transition from clearing on any write of 0.

// File: rtl/subtmr_pkg.sv
package subtmr_pkg;

    localparam logic [1:0] SEL_IVT  = 2'd0;
    localparam logic [1:0] SEL_SW   = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;

    localparam int L2_EN_BIT = 2;

    typedef enum logic {
        IVT_OFF = 1'b0,
        IVT_RUN = 1'b1
    } ivt_state_e;

    typedef enum logic {
        L2_IDLE = 1'b0,
        L2_PEND = 1'b1
    } l2_state_e;

endpackage

// File: rtl/subtmr_interval.sv
module subtmr_interval
    import subtmr_pkg::*;
#(
    parameter int PRESCALE = 384,
    parameter int N_W      = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [N_W-1:0] wdata_i,
    input  logic           ack_i,
    output logic [N_W-1:0] n_o,
    output logic           irq_o
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    ivt_state_e     state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [N_W-1:0] n_q;
    logic [N_W-1:0] cnt_q;
    logic           irq_q;
    logic           tick;
    logic           expire;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IVT_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IVT_OFF: if (wr_i && (wdata_i != '0)) state_d = IVT_RUN;
            IVT_RUN: if (wr_i && (wdata_i == '0)) state_d = IVT_OFF;
            default: state_d = IVT_OFF;
        endcase
    end

    assign tick   = (state_q == IVT_RUN) && !wr_i && (pre_q == PRE_LAST);
    assign expire = tick && (cnt_q == '0);

    // prescaler and period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            n_q   <= '0;
            cnt_q <= '0;
        end else if (wr_i) begin
            pre_q <= '0;
            n_q   <= wdata_i;
            cnt_q <= wdata_i;
        end else if (state_q == IVT_RUN) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (cnt_q == '0) cnt_q <= n_q;
                else             cnt_q <= cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // output request
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (expire) irq_q <= 1'b1;
        else if (ack_i)  irq_q <= 1'b0;
    end

    assign n_o   = n_q;
    assign irq_o = irq_q;

    AST_IRQ3_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack_i) |=> irq_q); // R5
    AST_IRQ3_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(state_q == IVT_RUN)); // R3
    AST_OFF_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IVT_OFF) |-> (pre_q == '0)); // R3
    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (pre_q == '0)); // R6

endmodule

// File: rtl/subtmr_stopwatch.sv
module subtmr_stopwatch #(
    parameter int PRESCALE = 384,
    parameter int SW_W     = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    output logic [SW_W-1:0] count_o
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_q;
    logic [SW_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    AST_SW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == SW_W'($past(cnt_q) + 1'b1)))); // R7
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/subtmr_l2latch.sv
module subtmr_l2latch
    import subtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic mask_off_i,
    input  logic en_i,
    output logic pend_o,
    output logic irq_o
);

    l2_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= L2_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            L2_IDLE: if (set_i) state_d = L2_PEND;
            L2_PEND: if (!set_i && (ack_i || mask_off_i)) state_d = L2_IDLE;
            default: state_d = L2_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == L2_PEND);
        irq_o  = (state_q == L2_PEND) && en_i;
    end

    AST_L2_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o); // R9
    AST_L2_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !pend_o); // R10
    AST_L2_MASKOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_off_i && !set_i) |=> !pend_o); // R11
    AST_L2_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack_i && !mask_off_i) |=> pend_o); // R9

endmodule

// File: rtl/subcpu_timers.sv
module subcpu_timers
    import subtmr_pkg::*;
#(
    parameter int PRESCALE = 384,
    parameter int WD_W     = 8,
    parameter int SW_W     = 12,
    parameter int RD_W     = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_sel,
    input  logic [WD_W-1:0] reg_wdata,
    output logic [RD_W-1:0] reg_rdata,
    input  logic            main_we,
    input  logic            main_bit,
    output logic [1:0]      main_status,
    output logic            irq2_req,
    input  logic            irq2_ack,
    output logic            irq3_req,
    input  logic            irq3_ack
);

    logic            ivt_wr;
    logic            sw_clr;
    logic            mask_wr;
    logic            mask_off;
    logic [WD_W-1:0] mask_q;
    logic [WD_W-1:0] ivt_n;
    logic [SW_W-1:0] sw_count;
    logic            l2_pend;

    assign ivt_wr   = reg_we && (reg_sel == SEL_IVT);
    assign sw_clr   = reg_we && (reg_sel == SEL_SW);
    assign mask_wr  = reg_we && (reg_sel == SEL_MASK);
    assign mask_off = mask_wr && mask_q[L2_EN_BIT] && !reg_wdata[L2_EN_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= reg_wdata;
    end

    subtmr_interval #(
        .PRESCALE (PRESCALE),
        .N_W      (WD_W)
    ) u_ivt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ivt_wr),
        .wdata_i (reg_wdata),
        .ack_i   (irq3_ack),
        .n_o     (ivt_n),
        .irq_o   (irq3_req)
    );

    subtmr_stopwatch #(
        .PRESCALE (PRESCALE),
        .SW_W     (SW_W)
    ) u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (sw_clr),
        .count_o (sw_count)
    );

    subtmr_l2latch u_l2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (main_we && main_bit),
        .ack_i      (irq2_ack),
        .mask_off_i (mask_off),
        .en_i       (mask_q[L2_EN_BIT]),
        .pend_o     (l2_pend),
        .irq_o      (irq2_req)
    );

    assign main_status = {mask_q[L2_EN_BIT], l2_pend};

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_IVT:  reg_rdata = RD_W'(ivt_n);
            SEL_SW:   reg_rdata = RD_W'(sw_count);
            SEL_MASK: reg_rdata = RD_W'(mask_q);
            default:  reg_rdata = '0;
        endcase
    end

    AST_IRQ2_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq2_req |-> main_status[1]); // R12
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q)); // R13

endmodule

// File: tb/subcpu_timers_bench.sv
`timescale 1ns/1ps
module subcpu_timers_bench;

    localparam int PRE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [15:0] reg_rdata;
    logic        main_we = 1'b0;
    logic        main_bit = 1'b0;
    logic [1:0]  main_status;
    logic        irq2_req;
    logic        irq2_ack = 1'b0;
    logic        irq3_req;
    logic        irq3_ack = 1'b0;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int wr_at = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    subcpu_timers #(.PRESCALE(PRE)) u_subcpu_timers (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .main_we(main_we),
        .main_bit(main_bit), .main_status(main_status), .irq2_req(irq2_req),
        .irq2_ack(irq2_ack), .irq3_req(irq3_req), .irq3_ack(irq3_ack)
    );

    function automatic int f_period(int n);
        return (n + 1) * PRE;
    endfunction

    function automatic int f_sw(int k);
        return k % 4096;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        wr_at = cyc;
    endtask

    task automatic reg_read(logic [1:0] s, output int v);
        reg_sel = s;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic main_write(logic b);
        @(negedge clk);
        main_we = 1'b1; main_bit = b;
        @(negedge clk);
        main_we = 1'b0;
    endtask

    task automatic pulse_ack3();
        @(negedge clk);
        irq3_ack = 1'b1;
        @(negedge clk);
        irq3_ack = 1'b0;
    endtask

    task automatic pulse_ack2();
        @(negedge clk);
        irq2_ack = 1'b1;
        @(negedge clk);
        irq2_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        finish_run();
    end

    initial begin
        int v;
        int n;
        int w;
        int k;
        v = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq3_req == 1'b0, "R1 irq3", irq3_req, 0);
        chk(irq2_req == 1'b0, "R1 irq2", irq2_req, 0);
        chk(main_status == 2'b00, "R1 status", main_status, 0);
        reg_read(2'd0, v); chk(v == 0, "R1 interval", v, 0);
        reg_read(2'd1, v); chk(v == 0, "R1 stopwatch", v, 0);
        reg_read(2'd2, v); chk(v == 0, "R1 mask", v, 0);

        // R2 R4 R5: random small N values
        for (int i = 0; i < 6; i++) begin
            n = 1 + ($urandom % 6);
            reg_write(2'd0, 8'(n));
            w = wr_at;
            reg_read(2'd0, v); chk(v == n, "R4 readback", v, n);
            wait_to(w + f_period(n) - 1);
            chk(irq3_req == 1'b0, "R2 early", irq3_req, 0);
            wait_to(w + f_period(n));
            chk(irq3_req == 1'b1, "R2 on time", irq3_req, 1);
            wait_to(w + f_period(n) + 5);
            chk(irq3_req == 1'b1, "R5 held", irq3_req, 1);
            pulse_ack3();
            chk(irq3_req == 1'b0, "R5 ack clears", irq3_req, 0);
            wait_to(w + 2 * f_period(n) - 1);
            chk(irq3_req == 1'b0, "R2 second early", irq3_req, 0);
            wait_to(w + 2 * f_period(n));
            chk(irq3_req == 1'b1, "R2 reload", irq3_req, 1);
            pulse_ack3();
        end

        // R3 stop after running
        reg_write(2'd0, 8'd0);
        w = wr_at;
        wait_to(w + 3 * f_period(7));
        chk(irq3_req == 1'b0, "R3 stopped", irq3_req, 0);
        reg_read(2'd0, v); chk(v == 0, "R4 zero readback", v, 0);

        // R3 stop before first expiry
        reg_write(2'd0, 8'd2);
        wait_to(wr_at + 10);
        reg_write(2'd0, 8'd0);
        wait_to(wr_at + 4 * f_period(2));
        chk(irq3_req == 1'b0, "R3 cancelled", irq3_req, 0);

        // R6 rewrite restarts the prescaler
        reg_write(2'd0, 8'd2);
        w = wr_at;
        wait_to(w + 30);
        reg_write(2'd0, 8'd2);
        k = wr_at;
        wait_to(w + f_period(2));
        chk(irq3_req == 1'b0, "R6 old timing", irq3_req, 0);
        wait_to(k + f_period(2) - 1);
        chk(irq3_req == 1'b0, "R6 early", irq3_req, 0);
        wait_to(k + f_period(2));
        chk(irq3_req == 1'b1, "R6 restarted", irq3_req, 1);
        reg_write(2'd0, 8'd0);
        pulse_ack3();

        // R7 R8 stopwatch
        reg_write(2'd1, 8'hA5);
        w = wr_at;
        reg_read(2'd1, v); chk(v == 0, "R8 cleared", v, 0);
        k = 0;
        for (int i = 0; i < 5; i++) begin
            k = k + 1 + ($urandom % 9);
            wait_to(w + k * PRE - 1);
            reg_read(2'd1, v); chk(v == f_sw(k - 1), "R7 before step", v, f_sw(k - 1));
            wait_to(w + k * PRE);
            reg_read(2'd1, v); chk(v == f_sw(k), "R7 step", v, f_sw(k));
        end
        wait_to(w + k * PRE + 7);
        reg_write(2'd1, 8'h00);
        w = wr_at;
        reg_read(2'd1, v); chk(v == 0, "R8 mid clear", v, 0);
        wait_to(w + PRE - 1);
        reg_read(2'd1, v); chk(v == 0, "R8 prescaler cleared", v, 0);
        wait_to(w + 4095 * PRE);
        reg_read(2'd1, v); chk(v == f_sw(4095), "R7 top", v, 4095);
        wait_to(w + 4096 * PRE);
        reg_read(2'd1, v); chk(v == f_sw(4096), "R7 wrap", v, 0);

        // R9 R12 level-2 set while disabled
        main_write(1'b1);
        chk(main_status == 2'b01, "R9 pending", main_status, 1);
        chk(irq2_req == 1'b0, "R12 masked", irq2_req, 0);
        main_write(1'b0);
        chk(main_status == 2'b01, "R9 zero no effect", main_status, 1);
        // R11 write off while already off keeps flag
        reg_write(2'd2, 8'h00);
        chk(main_status == 2'b01, "R11 off-to-off", main_status, 1);
        // R13 R12 enable
        reg_write(2'd2, 8'h5C);
        reg_read(2'd2, v); chk(v == 8'h5C, "R13 mask read", v, 8'h5C);
        chk(main_status == 2'b11, "R12 status", main_status, 3);
        chk(irq2_req == 1'b1, "R12 request", irq2_req, 1);
        // R10 ack
        pulse_ack2();
        chk(main_status == 2'b10, "R10 ack clears", main_status, 2);
        chk(irq2_req == 1'b0, "R10 request low", irq2_req, 0);
        // R11 stays on
        main_write(1'b1);
        reg_write(2'd2, 8'h04);
        chk(main_status == 2'b11, "R11 on-to-on", main_status, 3);
        // R11 on-to-off clears
        reg_write(2'd2, 8'hFB);
        chk(main_status == 2'b00, "R11 disable clears", main_status, 0);
        chk(irq2_req == 1'b0, "R11 request low", irq2_req, 0);
        reg_read(2'd2, v); chk(v == 8'hFB, "R13 mask read 2", v, 8'hFB);

        finish_run();
    end

endmodule